// File: doc/BRIEF.md
# Byte-Mode I2C Master

This block is a single-target I2C master that a host steps through a transaction one byte at a time. The host talks to it through a small bank of 16-bit registers: control, command, data, status and interrupt status. Writing the command register opens a transaction with a START and an address byte that carries the 7-bit target address and the direction. After each completed byte the block flags an interrupt and parks with SCL pulled low. It moves on only when the host sets the cpu-ready control bit.

In a write, each cpu-ready either sends the byte held in the low half of the data register or, if the transmit-end bit is set, closes the transfer with STOP. Setting transmit-end at the first hold after the address gives a zero-length quick command. In a read, each received byte appears in the high half of the data register. The byte is answered with ACK, or with NACK when the receive-end bit was set as that byte began, and a NACKed byte is followed at once by STOP. A command written while the block is parked produces a repeated START instead of a STOP.

Both bus lines are open-drain: an output enable of 1 pulls the line low. SCL runs at four quarter-bit phases of `DIV` clocks each and honours clock stretching. If a stretch lasts `TMO` cycles, the block flags a timeout, releases both lines and returns to idle.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, status bit 0 (bus ready) is 1, irq is 0, and both SCL and SDA are released.
- R2: A write to the command register (offset 1; bits 6:0 address, bit 10 read) while the control enable bit (offset 0 bit 0) is 1 and the block is idle or parked issues START and then the byte {address, read}. While enable is 0 the write is ignored.
- R3: After each completed byte (an ACKed write address, a write data byte or a read data byte), ISR bit 0 (offset 4) is set and irq rises. The block then holds SCL low until cpu-ready (control bit 1) is 1, and clears cpu-ready when it acts on it.
- R4: In a write, cpu-ready with transmit-end (control bit 2) clear sends data register bits 7:0. With transmit-end set, the block issues STOP instead, which also gives a quick command when done at the first hold.
- R5: A NACK on a write data byte sets status bit 1. Status bit 1 is cleared when a new transaction starts.
- R6: In a read, each byte appears in data register bits 15:8. The byte is ACKed unless receive-end (control bit 3) was 1 when the byte began. A NACKed byte is followed by STOP without waiting for cpu-ready.
- R7: An address NACK sets ISR bit 1, leaves ISR bit 0 clear and ends the transaction with STOP.
- R8: A command written while the block is parked issues a repeated START with no STOP before it.
- R9: ISR bits are cleared by writing 1 to them. Bits written with 0 are kept. irq is the OR of the ISR bits.
- R10: Status bit 0 is 1 exactly when no transaction is in progress. While it is 1, both lines are released.
- R11: The block waits while a target stretches SCL. If SCL stays low for `TMO` cycles after the block released it, the block sets ISR bit 2, returns to idle and releases both lines.
- R12: SDA changes while SCL is high only as part of START or STOP, or when the block aborts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| irq | output | 1 | Interrupt, OR of ISR bits |
| scl_in | input | 1 | Sensed SCL line level |
| sda_in | input | 1 | Sensed SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
Register reads are combinational, so the bench samples them in the same cycle one clock-low phase after it sets the address. A register write takes effect at the next rising edge. Bus results arrive only after a full byte of 36 quarter-phases plus any stretching, so the bench never counts cycles for them. It polls irq or bus ready with a bounded wait, sampling on the falling edge, and then checks the data, ISR and status bits together with what the bench's target model logged. Hold behaviour is checked by waiting hundreds of cycles without cpu-ready and confirming that SCL is still low and the bus is not ready.

// File: rtl/i2c_byte_master.sv
module i2c_byte_master #(
  parameter int DIV = 4,
  parameter int TMO = 100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        irq,
  input  logic        scl_in,
  input  logic        sda_in,
  output logic        scl_oe,
  output logic        sda_oe
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int TW = $clog2(TMO + 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_XFER, S_HOLD, S_STOP} st_t;

  st_t st;
  logic [1:0] ph;
  logic [DW-1:0] dcnt;
  logic [TW-1:0] tcnt;
  logic en, rdy_cpu, tx_end, rx_end, cmd_rd, dnack, is_addr, nack_out, ackb;
  logic [6:0] cmd_addr;
  logic [7:0] txd, rxd, sh;
  logic [3:0] bitn;
  logic [2:0] isr;

  wire tick    = dcnt == DW'(DIV - 1);
  wire wr_ctrl = reg_we && reg_addr == 3'd0;
  wire wr_cmd  = reg_we && reg_addr == 3'd1;
  wire wr_data = reg_we && reg_addr == 3'd2;
  wire wr_isr  = reg_we && reg_addr == 3'd4;
  wire go      = wr_cmd && en && (st == S_IDLE || st == S_HOLD);
  wire stretch = st != S_IDLE && !scl_oe && !scl_in;
  wire tmo_hit = stretch && tcnt == TW'(TMO - 1);
  wire sender  = is_addr || !cmd_rd;

  assign irq = |isr;

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {12'd0, rx_end, tx_end, rdy_cpu, en};
      3'd1:    reg_rdata = {5'd0, cmd_rd, 3'd0, cmd_addr};
      3'd2:    reg_rdata = {rxd, txd};
      3'd3:    reg_rdata = {14'd0, dnack, st == S_IDLE};
      3'd4:    reg_rdata = {13'd0, isr};
      default: reg_rdata = 16'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= '0; dcnt <= '0; tcnt <= '0;
      en <= 1'b0; rdy_cpu <= 1'b0; tx_end <= 1'b0; rx_end <= 1'b0;
      cmd_rd <= 1'b0; cmd_addr <= '0; txd <= '0; rxd <= '0; sh <= '0;
      dnack <= 1'b0; is_addr <= 1'b0; nack_out <= 1'b0; ackb <= 1'b0;
      bitn <= '0; isr <= '0; scl_oe <= 1'b0; sda_oe <= 1'b0;
    end else begin
      dcnt <= tick ? '0 : dcnt + 1'b1;
      tcnt <= stretch ? tcnt + 1'b1 : '0;
      if (wr_ctrl) {rx_end, tx_end, rdy_cpu, en} <= reg_wdata[3:0];
      if (wr_data) txd <= reg_wdata[7:0];
      if (wr_isr)  isr <= isr & ~reg_wdata[2:0];
      if (tmo_hit) begin
        st <= S_IDLE; scl_oe <= 1'b0; sda_oe <= 1'b0; isr[2] <= 1'b1; rdy_cpu <= 1'b0;
      end else if (go) begin
        st <= S_START; ph <= '0; bitn <= '0; is_addr <= 1'b1; dnack <= 1'b0; rdy_cpu <= 1'b0;
        cmd_addr <= reg_wdata[6:0]; cmd_rd <= reg_wdata[10];
        sh <= {reg_wdata[6:0], reg_wdata[10]};
      end else begin
        case (st)
          S_HOLD: begin
            ph <= '0; bitn <= '0; sda_oe <= 1'b0;
            if (rdy_cpu) begin
              rdy_cpu <= 1'b0;
              if (cmd_rd) begin st <= S_XFER; nack_out <= rx_end; end
              else if (tx_end) st <= S_STOP;
              else begin st <= S_XFER; sh <= txd; end
            end
          end
          S_START: if (tick) begin
            case (ph)
              2'd0: begin sda_oe <= 1'b0; ph <= 2'd1; end
              2'd1: begin scl_oe <= 1'b0; ph <= 2'd2; end
              2'd2: if (scl_in) begin sda_oe <= 1'b1; ph <= 2'd3; end
              default: begin scl_oe <= 1'b1; ph <= 2'd0; st <= S_XFER; end
            endcase
          end
          S_XFER: if (tick) begin
            case (ph)
              2'd0: begin
                scl_oe <= 1'b1;
                sda_oe <= bitn[3] ? (!sender && !nack_out) : (sender && !sh[7]);
                ph <= 2'd1;
              end
              2'd1: begin scl_oe <= 1'b0; ph <= 2'd2; end
              2'd2: if (scl_in) begin
                if (bitn[3]) ackb <= sda_in;
                else sh <= {sh[6:0], sda_in};
                ph <= 2'd3;
              end
              default: begin
                scl_oe <= 1'b1; ph <= 2'd0;
                if (!bitn[3]) bitn <= bitn + 1'b1;
                else begin
                  bitn <= '0;
                  if (is_addr) begin
                    if (ackb) begin isr[1] <= 1'b1; st <= S_STOP; end
                    else begin
                      is_addr <= 1'b0;
                      if (cmd_rd) nack_out <= rx_end;
                      else begin isr[0] <= 1'b1; st <= S_HOLD; end
                    end
                  end else if (!cmd_rd) begin
                    dnack <= ackb; isr[0] <= 1'b1; st <= S_HOLD;
                  end else begin
                    rxd <= sh; isr[0] <= 1'b1; st <= nack_out ? S_STOP : S_HOLD;
                  end
                end
              end
            endcase
          end
          S_STOP: if (tick) begin
            case (ph)
              2'd0: begin sda_oe <= 1'b1; ph <= 2'd1; end
              2'd1: begin scl_oe <= 1'b0; ph <= 2'd2; end
              2'd2: if (scl_in) begin sda_oe <= 1'b0; ph <= 2'd3; end
              default: begin ph <= 2'd0; st <= S_IDLE; end
            endcase
          end
          default: ph <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_byte_master_chk.sv
module i2c_byte_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] st,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic [2:0] isr
);
  localparam logic [2:0] IDLE = 3'd0, START = 3'd1, HOLD = 3'd3, STOP = 3'd4;

  // R10
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == IDLE) |-> (!scl_oe && !sda_oe));

  // R3
  hold_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == HOLD) |-> scl_oe);

  // R11
  tmo_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(isr[2]) |-> (st == IDLE && !scl_oe && !sda_oe));

  // R7
  addr_nack_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(isr[1]) |-> (st == STOP && !$rose(isr[0])));

  // R12
  sda_while_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !scl_oe && !$past(scl_oe)) |-> (st == START || st == STOP || st == IDLE));
endmodule

bind i2c_byte_master i2c_byte_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .st(st), .scl_oe(scl_oe), .sda_oe(sda_oe), .isr(isr)
);

// File: tb/i2c_byte_master_bench.sv
module i2c_byte_master_bench;
  localparam int CLK_NS = 10;
  localparam logic [6:0] ADR = 7'h2A;

  logic clk = 0, rst_n = 0, reg_we = 0;
  logic [2:0] reg_addr = 0;
  logic [15:0] reg_wdata = 0, reg_rdata;
  logic irq, scl_oe, sda_oe;
  logic s_hold = 0, s_drv = 0;
  wire scl_w = !(scl_oe || s_hold);
  wire sda_w = !(sda_oe || s_drv);

  int nchk = 0, nbad = 0;

  i2c_byte_master u_i2c_byte_master (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .scl_in(scl_w), .sda_in(sda_w), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  always #(CLK_NS/2) clk = ~clk;

  // target model
  int bitc = 0, wn = 0, mn = 0, rk = 0, nstart = 0, nstop = 0, nack_idx = -1;
  bit active = 0, in_addr = 0, matched = 0, srd = 0, sending = 0, mlast = 0;
  logic [7:0] sh = 0, tx = 0;
  logic [7:0] wlog [0:63];
  bit mlog [0:63];

  function automatic logic [7:0] rbyte(input int k);
    return 8'(k * 29 + 7);
  endfunction

  always @(negedge sda_w) if (scl_w) begin
    active = 1; in_addr = 1; bitc = -1; sending = 0; s_drv = 0; nstart++;
  end
  always @(posedge sda_w) if (scl_w) begin
    active = 0; s_drv = 0; nstop++;
  end
  always @(posedge scl_w) if (active) begin
    if (bitc >= 0 && bitc < 8) sh = {sh[6:0], sda_w};
    else if (bitc == 8 && srd && !in_addr) begin mlast = sda_w; mlog[mn] = sda_w; mn++; end
  end
  always @(negedge scl_w) if (active) begin
    bitc++;
    if (bitc == 9) begin
      bitc = 0;
      if (in_addr) begin in_addr = 0; sending = matched && srd; end
      else if (srd) sending = sending && !mlast;
      if (sending) begin tx = rbyte(rk); rk++; end
    end
    if (bitc == 8) begin
      if (in_addr) begin matched = (sh[7:1] == ADR); srd = sh[0]; s_drv = matched; end
      else if (!srd && matched) begin wlog[wn] = sh; s_drv = (wn != nack_idx); wn++; end
      else s_drv = 0;
    end else if (bitc >= 0 && bitc < 8) s_drv = sending && !tx[7-bitc];
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_irq(input string req);
    int n = 0;
    while (!irq && n < 5000) begin @(negedge clk); n++; end
    chk(irq, req, 0, 1);
  endtask

  task automatic wait_ready(input string req);
    logic [15:0] d;
    int n = 0;
    rd(3, d);
    while (!d[0] && n < 5000) begin rd(3, d); n++; end
    chk(d[0], req, d, 1);
  endtask

  task automatic do_write(input int len, input logic [7:0] dat [0:3]);
    logic [15:0] d;
    int w0 = wn, p0 = nstop;
    wr(0, 16'h1);
    wr(1, {9'd0, ADR});
    wait_irq("R3 address irq");
    rd(4, d); chk(d == 16'h1, "R3 isr after address", d, 1);
    wr(4, 16'h1);
    for (int i = 0; i < len; i++) begin
      wr(2, {8'h00, dat[i]});
      wr(0, 16'h3);
      wait_irq("R3 data irq");
      wr(4, 16'h1);
      rd(3, d); chk(d[1] == 0, "R5 no data nack", d[1], 0);
    end
    wr(0, 16'h7);
    wait_ready("R4 stop after tx_end");
    chk(wn - w0 == len, "R4 bytes received", wn - w0, len);
    for (int i = 0; i < len; i++)
      chk(wlog[w0+i] == dat[i], "R4 write data", wlog[w0+i], dat[i]);
    chk(nstop == p0 + 1, "R4 stop seen", nstop - p0, 1);
  endtask

  task automatic do_read(input int len);
    logic [15:0] d;
    int k0 = rk, m0 = mn;
    wr(0, len == 1 ? 16'h9 : 16'h1);
    wr(1, {5'd0, 1'b1, 3'd0, ADR});
    for (int i = 0; i < len; i++) begin
      wait_irq("R6 read irq");
      rd(2, d);
      chk(d[15:8] == rbyte(k0 + i), "R6 read data", d[15:8], rbyte(k0 + i));
      wr(4, 16'h1);
      if (i < len - 1) wr(0, i == len - 2 ? 16'hB : 16'h3);
    end
    wait_ready("R6 stop after nack");
    chk(mn - m0 == len, "R6 ack slots", mn - m0, len);
    for (int i = 0; i < len; i++)
      chk(mlog[m0+i] == (i == len - 1), "R6 ack/nack", mlog[m0+i], i == len - 1);
  endtask

  initial begin
    #(CLK_NS * 150000);
    nbad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", nchk + 1, nbad);
    $finish;
  end

  initial begin
    logic [15:0] d;
    logic [7:0] dat [0:3];
    int s0, p0, w0;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(3, d); chk(d[0] == 1, "R1 ready after reset", d, 1);
    chk(irq == 0, "R1 irq after reset", irq, 0);
    chk(scl_w && sda_w, "R1 lines released", {scl_w, sda_w}, 3);

    // R2: command ignored while disabled
    s0 = nstart;
    wr(0, 16'h0);
    wr(1, {9'd0, ADR});
    repeat (100) @(negedge clk);
    rd(3, d); chk(d[0] == 1, "R2 disabled stays ready", d, 1);
    chk(nstart == s0, "R2 disabled no start", nstart - s0, 0);

    // random writes and reads
    for (int t = 0; t < 4; t++) begin
      int len = 1 + int'($urandom % 4);
      for (int i = 0; i < 4; i++) dat[i] = 8'($urandom);
      do_write(len, dat);
      do_read(1 + int'($urandom % 4));
    end

    // R3: hold with scl low until cpu ready, cpu ready cleared
    wr(0, 16'h1);
    wr(1, {9'd0, ADR});
    wait_irq("R3 irq");
    wr(4, 16'h1);
    repeat (300) @(negedge clk);
    chk(scl_w == 0, "R3 scl held low", scl_w, 0);
    rd(3, d); chk(d[0] == 0, "R10 busy while held", d[0], 0);
    wr(2, 16'h00C3);
    wr(0, 16'h3);
    wait_irq("R3 irq byte");
    rd(0, d); chk(d[1] == 0, "R3 cpu ready cleared", d[1], 0);
    wr(4, 16'h1);

    // R8: repeated start into a one-byte read
    s0 = nstart; p0 = nstop; w0 = rk;
    wr(0, 16'h9);
    wr(1, {5'd0, 1'b1, 3'd0, ADR});
    wait_irq("R8 read irq");
    rd(2, d); chk(d[15:8] == rbyte(w0), "R8 read data", d[15:8], rbyte(w0));
    wr(4, 16'h1);
    wait_ready("R8 ready");
    chk(nstart == s0 + 1 && nstop == p0 + 1, "R8 one stop one restart",
        (nstart - s0) * 16 + nstop - p0, 16'h11);
    chk(wlog[wn-1] == 8'hC3, "R4 byte before restart", wlog[wn-1], 8'hC3);

    // R7 and R9: address nack, write-one-to-clear
    p0 = nstop;
    wr(0, 16'h1);
    wr(1, 16'h0011);
    wait_irq("R7 irq");
    rd(4, d); chk(d == 16'h2, "R7 isr addr nack", d, 2);
    wait_ready("R7 ready");
    chk(nstop == p0 + 1, "R7 stop", nstop - p0, 1);
    wr(4, 16'h1);
    rd(4, d); chk(d == 16'h2, "R9 zero bits kept", d, 2);
    chk(irq == 1, "R9 irq with bit set", irq, 1);
    wr(4, 16'h2);
    rd(4, d); chk(d == 16'h0, "R9 cleared", d, 0);
    chk(irq == 0, "R9 irq low", irq, 0);

    // R4: quick command
    w0 = wn; p0 = nstop;
    wr(0, 16'h1);
    wr(1, {9'd0, ADR});
    wait_irq("R4 quick irq");
    wr(4, 16'h1);
    wr(0, 16'h7);
    wait_ready("R4 quick ready");
    chk(wn == w0, "R4 quick no data", wn - w0, 0);
    chk(nstop == p0 + 1, "R4 quick stop", nstop - p0, 1);

    // R5: data nack on second byte
    nack_idx = wn + 1;
    wr(0, 16'h1);
    wr(1, {9'd0, ADR});
    wait_irq("R5 irq"); wr(4, 16'h1);
    wr(2, 16'h0011); wr(0, 16'h3);
    wait_irq("R5 irq 1"); wr(4, 16'h1);
    rd(3, d); chk(d[1] == 0, "R5 first byte acked", d[1], 0);
    wr(2, 16'h0022); wr(0, 16'h3);
    wait_irq("R5 irq 2"); wr(4, 16'h1);
    rd(3, d); chk(d[1] == 1, "R5 data nack flag", d[1], 1);
    wr(0, 16'h7);
    wait_ready("R5 ready");
    nack_idx = -1;

    // R11: short stretch is honoured
    w0 = wn;
    wr(0, 16'h1);
    wr(1, {9'd0, ADR});
    wait_irq("R11 irq"); wr(4, 16'h1);
    s_hold = 1;
    wr(2, 16'h005A); wr(0, 16'h3);
    repeat (40) @(negedge clk);
    s_hold = 0;
    wait_irq("R11 irq after stretch");
    rd(4, d); chk(d == 16'h1, "R11 no timeout on short stretch", d, 1);
    wr(4, 16'h1);
    wr(0, 16'h7);
    wait_ready("R11 ready");
    chk(wlog[w0] == 8'h5A, "R11 byte after stretch", wlog[w0], 8'h5A);

    // R11: long stretch times out
    wr(0, 16'h1);
    wr(1, {9'd0, ADR});
    wait_irq("R11 irq"); wr(4, 16'h1);
    s_hold = 1;
    wr(2, 16'h0000); wr(0, 16'h3);
    wait_irq("R11 timeout irq");
    rd(4, d); chk(d == 16'h4, "R11 timeout flag", d, 4);
    rd(3, d); chk(d[0] == 1, "R11 idle after timeout", d[0], 1);
    chk(!scl_oe && !sda_oe, "R11 lines released", {scl_oe, sda_oe}, 0);
    s_hold = 0;
    wr(4, 16'h4);
    repeat (20) @(negedge clk);
    chk(scl_w && sda_w, "R10 bus idle high", {scl_w, sda_w}, 3);

    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule